// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records the value of a free-running 32-bit raw time counter when a chosen trigger occurs. The trigger is either an asynchronous event-request pin, taken on a programmable edge, or a synchronous one-cycle pulse-per-second strobe from inside the chip. Once a timestamp has been recorded the unit flags it as valid and refuses further captures until software acknowledges it. A later trigger arriving in that window is counted as a miss and raises a sticky error flag. An overwrite mode is also available, in which each new trigger replaces the held value.

A host reaches the unit through a simple 16-bit register port. Writes are single-cycle strobes and reads are combinational from the address. There are four words: a configuration word, a status word, and the two halves of the captured timestamp, placed directly after the status word with the low half first. The status word also holds a small capture counter. The counter advances only when the configuration enables it, saturates at its maximum, and clears whenever the status word is written.

Top module: `evt_stamp_capture`

## Requirements
- R1: After synchronous reset every readable word is zero: configuration, status (valid, error, source, counter) and both timestamp halves.
- R2: The event-request pin passes through a two-flop synchroniser, so a pin change driven between clock edges is stored with the time counter value present at the third rising clock edge after the change.
- R3: Configuration bit 0 (address 0) selects the pin edge. When it is 0, only a rising edge of the synchronised pin is an event. When it is 1, only a falling edge is an event.
- R4: Status bit 2 (address 1) selects the trigger source. When it is 1, the pulse-per-second strobe is the event, sampled on the clock edge where it is high. When it is 0, the pin is the event. The source that is not selected has no effect.
- R5: An event stored into an empty holder sets status bit 0 (valid). While valid is set and overwrite is off, an event leaves the timestamp unchanged and sets status bit 1 (missed-event error).
- R6: The error bit stays set until a status write with bit 1 equal to 0. A status write with bit 1 equal to 1 leaves it as it was.
- R7: When configuration bit 1 (overwrite) is set, every event stores a new timestamp, even while valid is set, and the error bit is not raised.
- R8: Status bits 15:8 count stored captures only while configuration bit 2 (counter start) is set. The count stops at 255 instead of wrapping.
- R9: Any write to the status word clears the capture counter. It clears valid when bit 0 of the written data is 0 and leaves valid as it was when bit 0 is 1.
- R10: Address 2 reads timestamp bits 15:0 and address 3 reads bits 31:16. Writes to these two addresses are ignored.
- R11: When a status write and an event fall on the same clock edge, the write takes effect first and the event is then judged against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_cnt | input | 32 | Raw time counter value to capture |
| ext_req | input | 1 | Asynchronous event-request pin |
| pps_pulse | input | 1 | Synchronous one-cycle pulse-per-second strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 config, 1 status, 2 stamp low, 3 stamp high) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |

## Verification
Two cases are the hardest to reach from the ports. The first is a status write on the very clock edge where a trigger fires, which needs the strobe and the write strobe lined up exactly; the bench uses the synchronous pulse source so it can place both in the same cycle. The second is counter saturation, which needs more than 255 stored captures; the bench enables overwrite and holds the pulse high for 300 cycles, so every cycle stores a capture. A behavioural reference model runs on every clock and compares the word currently addressed. That comparison covers the three-edge pin latency and the miss handling.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;

    typedef enum logic [1:0] {
        ADDR_CFG   = 2'd0,
        ADDR_STAT  = 2'd1,
        ADDR_TS_LO = 2'd2,
        ADDR_TS_HI = 2'd3
    } reg_addr_e;

    // configuration word bit positions
    localparam int CFG_FALL_BIT  = 0;
    localparam int CFG_OW_BIT    = 1;
    localparam int CFG_START_BIT = 2;

    // status word bit positions
    localparam int ST_VALID_BIT = 0;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_SRC_BIT   = 2;
    localparam int ST_CNT_LSB   = 8;

    typedef struct packed {
        logic start;
        logic overwrite;
        logic falling;
    } cap_cfg_t;

    function automatic logic edge_hit(logic cur, logic prev, logic falling);
        return falling ? (prev & ~cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    input  logic falling,
    output logic edge_o
);
    import evt_cap_pkg::*;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= pin_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign edge_o = edge_hit(sync_q[STAGES-1], prev_q, falling);

endmodule

// File: rtl/evt_cap_core.sv
module evt_cap_core #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      event_i,
    input  logic [TS_W-1:0]           time_i,
    input  evt_cap_pkg::cap_cfg_t     cfg,
    input  logic                      stat_wr,
    input  logic                      keep_valid,
    input  logic                      keep_err,
    output logic                      valid_o,
    output logic                      err_o,
    output logic [CNT_W-1:0]          cnt_o,
    output logic [TS_W-1:0]           ts_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             valid_eff, err_eff, store, miss;
    logic [CNT_W-1:0] cnt_eff;

    always_comb begin
        // a status write is applied before the same-cycle event is judged
        valid_eff = stat_wr ? (valid_o & keep_valid) : valid_o;
        err_eff   = stat_wr ? (err_o & keep_err)     : err_o;
        cnt_eff   = stat_wr ? '0                     : cnt_o;
        store     = event_i & (~valid_eff | cfg.overwrite);
        miss      = event_i & ~store;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            cnt_o   <= '0;
            ts_o    <= '0;
        end else begin
            valid_o <= valid_eff | store;
            err_o   <= err_eff | miss;
            if (store) ts_o <= time_i;
            if (store && cfg.start && cnt_eff != CNT_MAX) cnt_o <= cnt_eff + 1'b1;
            else                                          cnt_o <= cnt_eff;
        end
    end

endmodule

// File: rtl/evt_cap_regs.sv
module evt_cap_regs #(
    parameter int REG_W = 16,
    parameter int CNT_W = 8,
    localparam int TS_W = 2 * REG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    input  logic                  cap_valid,
    input  logic                  cap_err,
    input  logic [CNT_W-1:0]      cap_cnt,
    input  logic [TS_W-1:0]       cap_ts,
    output evt_cap_pkg::cap_cfg_t cfg_o,
    output logic                  src_pps_o,
    output logic                  stat_wr_o,
    output logic                  keep_valid_o,
    output logic                  keep_err_o,
    output logic [REG_W-1:0]      reg_rdata
);
    import evt_cap_pkg::*;

    reg_addr_e addr;
    logic      cfg_wr;
    logic      wdata_unused;

    assign addr         = reg_addr_e'(reg_addr);
    assign cfg_wr       = reg_wr && (addr == ADDR_CFG);
    assign stat_wr_o    = reg_wr && (addr == ADDR_STAT);
    assign keep_valid_o = reg_wdata[ST_VALID_BIT];
    assign keep_err_o   = reg_wdata[ST_ERR_BIT];
    assign wdata_unused = ^reg_wdata[REG_W-1:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o     <= '0;
            src_pps_o <= 1'b0;
        end else begin
            if (cfg_wr) begin
                cfg_o.falling   <= reg_wdata[CFG_FALL_BIT];
                cfg_o.overwrite <= reg_wdata[CFG_OW_BIT];
                cfg_o.start     <= reg_wdata[CFG_START_BIT];
            end
            if (stat_wr_o) src_pps_o <= reg_wdata[ST_SRC_BIT];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            ADDR_CFG: begin
                reg_rdata[CFG_FALL_BIT]  = cfg_o.falling;
                reg_rdata[CFG_OW_BIT]    = cfg_o.overwrite;
                reg_rdata[CFG_START_BIT] = cfg_o.start;
            end
            ADDR_STAT: begin
                reg_rdata[ST_VALID_BIT]             = cap_valid;
                reg_rdata[ST_ERR_BIT]               = cap_err;
                reg_rdata[ST_SRC_BIT]               = src_pps_o;
                reg_rdata[ST_CNT_LSB +: CNT_W]      = cap_cnt;
            end
            ADDR_TS_LO: reg_rdata = cap_ts[REG_W-1:0];
            ADDR_TS_HI: reg_rdata = cap_ts[TS_W-1:REG_W];
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture #(
    parameter int REG_W       = 16,
    parameter int CNT_W       = 8,   // must not exceed REG_W - 8
    parameter int SYNC_STAGES = 2,   // at least 2
    localparam int TS_W       = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TS_W-1:0]  time_cnt,
    input  logic             ext_req,
    input  logic             pps_pulse,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    import evt_cap_pkg::*;

    cap_cfg_t         cfg;
    logic             src_pps, stat_wr, keep_valid, keep_err;
    logic             ext_edge, cap_event;
    logic             cap_valid, cap_err;
    logic [CNT_W-1:0] cap_cnt;
    logic [TS_W-1:0]  cap_ts;

    evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_req),
        .falling   (cfg.falling),
        .edge_o    (ext_edge)
    );

    assign cap_event = src_pps ? pps_pulse : ext_edge;

    evt_cap_core #(.TS_W(TS_W), .CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .event_i    (cap_event),
        .time_i     (time_cnt),
        .cfg        (cfg),
        .stat_wr    (stat_wr),
        .keep_valid (keep_valid),
        .keep_err   (keep_err),
        .valid_o    (cap_valid),
        .err_o      (cap_err),
        .cnt_o      (cap_cnt),
        .ts_o       (cap_ts)
    );

    evt_cap_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .cap_valid    (cap_valid),
        .cap_err      (cap_err),
        .cap_cnt      (cap_cnt),
        .cap_ts       (cap_ts),
        .cfg_o        (cfg),
        .src_pps_o    (src_pps),
        .stat_wr_o    (stat_wr),
        .keep_valid_o (keep_valid),
        .keep_err_o   (keep_err),
        .reg_rdata    (reg_rdata)
    );

endmodule

// File: rtl/evt_stamp_capture_chk.sv
module evt_stamp_capture_chk #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             stat_wr,
    input logic             cap_event,
    input logic             ow,
    input logic             cap_valid,
    input logic             cap_err,
    input logic [CNT_W-1:0] cap_cnt,
    input logic [TS_W-1:0]  cap_ts
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!cap_valid && !cap_err && cap_cnt == '0 && cap_ts == '0));

    // R5
    miss_keeps_ts_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !ow && cap_event && !stat_wr) |=> ($stable(cap_ts) && cap_err));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_err && !stat_wr) |=> cap_err);

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !stat_wr) |=> cap_valid);

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !cap_event) |=> (cap_cnt == '0));

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_cnt == CNT_MAX && !stat_wr) |=> (cap_cnt == CNT_MAX));

    // R7
    ow_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (ow && !cap_err && !stat_wr) |=> !cap_err);

endmodule

bind evt_stamp_capture evt_stamp_capture_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stat_wr   (stat_wr),
    .cap_event (cap_event),
    .ow        (cfg.overwrite),
    .cap_valid (cap_valid),
    .cap_err   (cap_err),
    .cap_cnt   (cap_cnt),
    .cap_ts    (cap_ts)
);

// File: tb/evt_stamp_capture_tb.sv
module evt_stamp_capture_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] time_cnt = 32'hFFF0_0010;
    logic        ext_req = 1'b0;
    logic        pps_pulse = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    evt_stamp_capture u_dut (
        .clk(clk), .rst(rst), .time_cnt(time_cnt), .ext_req(ext_req),
        .pps_pulse(pps_pulse), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // free-running time source, changes away from the active edge
    always @(negedge clk) time_cnt <= time_cnt + 32'h0001_0003;

    // ---------------- reference model ----------------
    bit          m_fall, m_ow, m_start, m_src, m_valid, m_err;
    int          m_cnt;
    logic [31:0] m_ts;
    bit          h1, h2, h3;   // pin samples at the previous three edges

    function automatic logic [15:0] model_read(logic [1:0] a);
        case (a)
            2'd0:    return {13'd0, m_start, m_ow, m_fall};
            2'd1:    return {m_cnt[7:0], 5'd0, m_src, m_err, m_valid};
            2'd2:    return m_ts[15:0];
            default: return m_ts[31:16];
        endcase
    endfunction

    task automatic model_step();
        bit ev, v, e;
        int c;
        if (rst) begin
            m_fall = 0; m_ow = 0; m_start = 0; m_src = 0;
            m_valid = 0; m_err = 0; m_cnt = 0; m_ts = '0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            ev = m_src ? pps_pulse : (m_fall ? (h3 && !h2) : (!h3 && h2));
            v = m_valid; e = m_err; c = m_cnt;
            if (reg_wr && reg_addr == 2'd1) begin
                v = v && reg_wdata[0];
                e = e && reg_wdata[1];
                c = 0;
            end
            if (ev) begin
                if (!v || m_ow) begin
                    m_ts = time_cnt;
                    v = 1;
                    if (m_start && c < 255) c++;
                end else e = 1;
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_fall = reg_wdata[0]; m_ow = reg_wdata[1]; m_start = reg_wdata[2];
            end
            if (reg_wr && reg_addr == 2'd1) m_src = reg_wdata[2];
            m_valid = v; m_err = e; m_cnt = c;
            h3 = h2; h2 = h1; h1 = ext_req;
        end
    endtask

    // model update on the edge, comparison 2 ns later on every clock
    always @(posedge clk) begin
        logic [15:0] exp_v;
        model_step();
        #2;
        if (!done) begin
            exp_v = model_read(reg_addr);
            n_checks++;
            if (reg_rdata !== exp_v) begin
                n_errors++;
                $display("FAIL %s model compare addr=%0d actual=%h expected=%h",
                         cur_req, reg_addr, reg_rdata, exp_v);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        #2;
        v = reg_rdata;
        @(negedge clk);
        reg_addr = 2'd1;
    endtask

    task automatic pulse_pps();
        @(negedge clk);
        pps_pulse = 1'b1;
        @(negedge clk);
        pps_pulse = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] v, lo0, hi0;
        tick(4);
        rst = 1'b0;

        // R1 reset values
        cur_req = "R1";
        rd(2'd1, v); chk("R1 status", v, 16'h0000);
        rd(2'd0, v); chk("R1 config", v, 16'h0000);
        rd(2'd2, v); chk("R1 stamp low", v, 16'h0000);
        rd(2'd3, v); chk("R1 stamp high", v, 16'h0000);

        // R2 / R3 rising edge capture with counter running
        cur_req = "R2";
        wr(2'd0, 16'h0004);
        @(negedge clk) ext_req = 1'b1;
        tick(6);
        rd(2'd1, v); chk("R2 valid and count after rising edge", v, 16'h0101);

        // R9 status write clears valid and counter
        cur_req = "R9";
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk("R9 valid and count cleared", v, 16'h0000);

        // R3 falling mode: rising ignored, falling captured
        cur_req = "R3";
        wr(2'd0, 16'h0005);
        @(negedge clk) ext_req = 1'b0;
        tick(6);
        rd(2'd1, v); chk("R3 falling edge captured", v, 16'h0101);
        wr(2'd1, 16'h0000);
        @(negedge clk) ext_req = 1'b1;
        tick(6);
        rd(2'd1, v); chk("R3 rising edge ignored in falling mode", v, 16'h0000);
        @(negedge clk) ext_req = 1'b0;
        tick(6);
        rd(2'd1, v); chk("R3 falling edge after rising", v, 16'h0101);

        // R5 miss while valid, stamp held
        cur_req = "R5";
        rd(2'd2, lo0);
        @(negedge clk) ext_req = 1'b1;
        tick(4);
        @(negedge clk) ext_req = 1'b0;
        tick(6);
        rd(2'd1, v); chk("R5 error raised on miss", v, 16'h0103);
        rd(2'd2, v); chk("R5 stamp unchanged by miss", v, lo0);

        // R6 sticky error
        cur_req = "R6";
        wr(2'd1, 16'h0003);
        rd(2'd1, v); chk("R6 error kept by write of one", v, 16'h0003);
        wr(2'd1, 16'h0001);
        rd(2'd1, v); chk("R6 error cleared by write of zero", v, 16'h0001);

        // R4 source select: pulse source, pin ignored
        cur_req = "R4";
        wr(2'd1, 16'h0004);
        @(negedge clk) ext_req = 1'b1;
        tick(4);
        @(negedge clk) ext_req = 1'b0;
        tick(6);
        rd(2'd1, v); chk("R4 pin ignored when pulse selected", v, 16'h0004);
        pulse_pps();
        tick(1);
        rd(2'd1, v); chk("R4 pulse captured", v, 16'h0105);

        // R7 overwrite
        cur_req = "R7";
        wr(2'd0, 16'h0006);
        rd(2'd2, lo0);
        for (int i = 0; i < 3; i++) begin
            pulse_pps();
            tick(2);
        end
        rd(2'd1, v); chk("R7 overwrite counts, no error", v, 16'h0405);
        rd(2'd2, v);
        n_checks++;
        if (v === lo0) begin
            n_errors++;
            $display("FAIL R7 stamp not replaced actual=%h expected=not %h", v, lo0);
        end

        // R8 counter halted without start bit, then saturation
        cur_req = "R8";
        wr(2'd0, 16'h0002);
        pulse_pps();
        tick(1);
        rd(2'd1, v); chk("R8 count frozen without start", v, 16'h0405);
        wr(2'd0, 16'h0006);
        @(negedge clk) pps_pulse = 1'b1;
        tick(300);
        @(negedge clk) pps_pulse = 1'b0;
        rd(2'd1, v); chk("R8 count saturates", v, 16'hFF05);

        // R11 status write on the same edge as a pulse
        cur_req = "R11";
        wr(2'd0, 16'h0004);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0004; pps_pulse = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; pps_pulse = 1'b0;
        rd(2'd1, v); chk("R11 event stored after same-edge clear", v, 16'h0105);

        // R10 stamp words are read-only
        cur_req = "R10";
        rd(2'd2, lo0);
        rd(2'd3, hi0);
        wr(2'd2, 16'hA5A5);
        wr(2'd3, 16'h5A5A);
        rd(2'd2, v); chk("R10 low half ignores write", v, lo0);
        rd(2'd3, v); chk("R10 high half ignores write", v, hi0);

        tick(3);
        finish_run();
    end

endmodule